// File: doc/BRIEF.md
# Direct-Mapped Address Translation Lookup

This block turns a virtual address into a physical address for one memory access per clock. It keeps two direct-mapped tables, one consulted for instruction fetches and one for loads and stores. Each entry holds a match word and a translate word. Software fills the entries through a write port that picks the table, the entry index and which of the two words to write.

A request carries the virtual address, the access type (fetch, load or store), a supervisor flag and the translation enable for each side. The block registers the request. During the following cycle it presents the physical address, the rights granted under the current privilege level and an exception code. It tells a page fault (a valid matching entry that lacks the needed right) apart from a table miss (no valid matching entry). On any exception it pulses a reservation-cancel output and latches the faulting virtual address.

Top module: `tlb_lookup`

## Requirements
- R1: `rsp_valid_o` is high in exactly the cycle after a cycle with `req_valid_i` high, and is low otherwise. The physical address, rights and exception code for that request are valid in that same cycle.
- R2: The entry index is virtual address bits [18:13]. An entry matches only when bit 0 of its match word (valid) is 1 and match word bits [31:13] equal virtual address bits [31:13]. Indices 0 and 63 behave like any other index.
- R3: The physical address is translate word bits [31:13] joined with virtual address bits [12:0].
- R4: `rsp_rights_o` bit 0 is read, bit 1 is write and bit 2 is execute. In supervisor mode the rights come from these bits: execute from instruction-table translate bit 6, read from data-table translate bit 8, write from data-table translate bit 9. In user mode they come from instruction bit 7 (execute), data bit 6 (read) and data bit 7 (write). Execute comes only from the instruction entry, and read and write only from the data entry. Each right is granted only when its entry is a valid match.
- R5: The needed right depends on `req_type_i`: 0 (fetch) needs execute, 2 (store) needs write, and 1 or 3 (load) need read. Exception codes are 0 none, 1 instruction miss, 2 data miss, 3 instruction page fault and 4 data page fault. The code is 0 when the needed right is granted. It is 3 or 4 when the needed side's entry is a valid match without the right, and 1 or 2 when that entry is not a valid match. Fetches use 1 and 3, and other accesses use 2 and 4.
- R6: When the two indexed translate words differ in bits [31:13], the entry on the side the access does not need is ignored: its rights are not reported and its page does not form the address. When the bits are equal, the rights of both sides are reported.
- R7: A fetch uses `itrans_en_i` and a load or store uses `dtrans_en_i`, both sampled with the request. When the used enable is 0, the physical address equals the virtual address, rights are 3'b111 and the exception code is 0.
- R8: In a response cycle with a nonzero exception code, `resv_cancel_o` is high. `fault_addr_o` shows that request's virtual address from the next cycle on, and responses without an exception leave it unchanged.
- R9: A table write (`wr_dtable_i` 0 instruction, 1 data; `wr_word_i` 0 match, 1 translate) is seen by every response after its clock edge. This includes a request presented in the same cycle as the write. A write to one table never changes lookups in the other.
- R10: After reset every entry is invalid, so any enabled lookup misses. `rsp_valid_o` and `resv_cancel_o` are 0 and `fault_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request strobe |
| req_vaddr_i | input | 32 | Virtual address |
| req_type_i | input | 2 | 0 fetch, 1 load, 2 store, 3 load |
| req_super_i | input | 1 | Supervisor mode when 1 |
| itrans_en_i | input | 1 | Instruction translation enable |
| dtrans_en_i | input | 1 | Data translation enable |
| wr_en_i | input | 1 | Table write strobe |
| wr_dtable_i | input | 1 | Table select: 0 instruction, 1 data |
| wr_idx_i | input | 6 | Entry index to write |
| wr_word_i | input | 1 | Word select: 0 match, 1 translate |
| wr_data_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_rights_o | output | 3 | Granted rights {x, w, r} |
| rsp_exc_o | output | 3 | Exception code |
| fault_addr_o | output | 32 | Last faulting virtual address |
| resv_cancel_o | output | 1 | Reservation cancel pulse |

## Verification
The bench targets the cases where the two tables disagree on the physical page. A design that skipped the discard rule would grant execute through a data entry, or would form the address from the wrong page. It separates a valid entry with a missing right from a tag mismatch that aliases to the same index; mixing these up swaps page-fault and miss codes. Per-side enables are exercised with only one side off, which catches a design that shares a single enable. Writes that land in the same cycle as a request, and resets in the middle of a run, expose stale entries or a late table update.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;
  localparam int RGT_R = 0;
  localparam int RGT_W = 1;
  localparam int RGT_X = 2;
  localparam int RGT_W_ALL = 3;

  // permission field inside the translate word
  localparam int PERM_LSB = 6;
  localparam int PERM_W   = 4;
  localparam int I_SX = 0;
  localparam int I_UX = 1;
  localparam int D_UR = 0;
  localparam int D_UW = 1;
  localparam int D_SR = 2;
  localparam int D_SW = 3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_LOAD2 = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    EXC_NONE      = 3'd0,
    EXC_ITLB_MISS = 3'd1,
    EXC_DTLB_MISS = 3'd2,
    EXC_IPAGE     = 3'd3,
    EXC_DPAGE     = 3'd4
  } exc_e;

  typedef struct packed {
    acc_e acc;
    logic sup;
    logic ien;
    logic den;
  } req_ctl_t;
endpackage

// File: rtl/tlb_table.sv
module tlb_table #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx_i,
  input  logic                       wr_word_i,
  input  logic [ADDR_W-1:0]          wr_data_i,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx_i,
  output logic [ADDR_W-1:0]          rd_match_o,
  output logic [ADDR_W-1:0]          rd_xlat_o
);
  logic [ADDR_W-1:0] match_q [ENTRIES];
  logic [ADDR_W-1:0] xlat_q  [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) begin
        match_q[e] <= '0;
        xlat_q[e]  <= '0;
      end
    end else if (wr_en_i) begin
      if (wr_word_i) xlat_q[wr_idx_i]  <= wr_data_i;
      else           match_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_match_o = match_q[rd_idx_i];
  assign rd_xlat_o  = xlat_q[rd_idx_i];
endmodule

// File: rtl/tlb_entry_decode.sv
module tlb_entry_decode
  import tlb_lookup_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter bit IS_INSTR  = 1'b0
) (
  input  logic [ADDR_W-1:0]           match_i,
  input  logic [ADDR_W-PAGE_BITS-1:0] vpn_i,
  input  logic [PERM_W-1:0]           perm_i,
  input  logic                        super_i,
  output logic                        hit_o,
  output logic [RGT_W_ALL-1:0]        rights_o
);
  logic unused_match;
  assign unused_match = ^match_i[PAGE_BITS-1:1];

  assign hit_o = match_i[0] && (match_i[ADDR_W-1:PAGE_BITS] == vpn_i);

  if (IS_INSTR) begin : g_instr
    logic unused_perm;
    assign unused_perm = ^perm_i[PERM_W-1:2];
    always_comb begin
      rights_o        = '0;
      rights_o[RGT_X] = hit_o && (super_i ? perm_i[I_SX] : perm_i[I_UX]);
    end
  end else begin : g_data
    always_comb begin
      rights_o        = '0;
      rights_o[RGT_R] = hit_o && (super_i ? perm_i[D_SR] : perm_i[D_UR]);
      rights_o[RGT_W] = hit_o && (super_i ? perm_i[D_SW] : perm_i[D_UW]);
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_lookup_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int ENTRIES   = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [ADDR_W-1:0]          req_vaddr_i,
  input  logic [1:0]                 req_type_i,
  input  logic                       req_super_i,
  input  logic                       itrans_en_i,
  input  logic                       dtrans_en_i,
  input  logic                       wr_en_i,
  input  logic                       wr_dtable_i,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx_i,
  input  logic                       wr_word_i,
  input  logic [ADDR_W-1:0]          wr_data_i,
  output logic                       rsp_valid_o,
  output logic [ADDR_W-1:0]          rsp_paddr_o,
  output logic [2:0]                 rsp_rights_o,
  output logic [2:0]                 rsp_exc_o,
  output logic [ADDR_W-1:0]          fault_addr_o,
  output logic                       resv_cancel_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VPN_W = ADDR_W - PAGE_BITS;
  localparam int NTAB  = 2;  // 0 instruction, 1 data

  logic              req_vld_q;
  logic [ADDR_W-1:0] req_va_q;
  req_ctl_t          req_ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_vld_q <= 1'b0;
      req_va_q  <= '0;
      req_ctl_q <= '{acc: ACC_FETCH, sup: 1'b0, ien: 1'b0, den: 1'b0};
    end else begin
      req_vld_q <= req_valid_i;
      if (req_valid_i) begin
        req_va_q  <= req_vaddr_i;
        req_ctl_q <= '{acc: acc_e'(req_type_i), sup: req_super_i,
                       ien: itrans_en_i, den: dtrans_en_i};
      end
    end
  end

  logic [IDX_W-1:0]  rd_idx;
  logic [VPN_W-1:0]  vpn;
  logic [ADDR_W-1:0] tab_match [NTAB];
  logic [ADDR_W-1:0] tab_xlat  [NTAB];
  logic [ADDR_W-1:0] sel_match [NTAB];
  logic [ADDR_W-1:0] sel_xlat  [NTAB];
  logic [2:0]        tab_rgt   [NTAB];
  logic              tab_hit   [NTAB];

  assign rd_idx = req_va_q[PAGE_BITS +: IDX_W];
  assign vpn    = req_va_q[ADDR_W-1:PAGE_BITS];

  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    tlb_table #(
      .ADDR_W (ADDR_W),
      .ENTRIES(ENTRIES)
    ) u_table (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i && (wr_dtable_i == 1'(t))),
      .wr_idx_i  (wr_idx_i),
      .wr_word_i (wr_word_i),
      .wr_data_i (wr_data_i),
      .rd_idx_i  (rd_idx),
      .rd_match_o(tab_match[t]),
      .rd_xlat_o (tab_xlat[t])
    );

    tlb_entry_decode #(
      .ADDR_W   (ADDR_W),
      .PAGE_BITS(PAGE_BITS),
      .IS_INSTR (t == 0)
    ) u_decode (
      .match_i (sel_match[t]),
      .vpn_i   (vpn),
      .perm_i  (sel_xlat[t][PERM_LSB +: PERM_W]),
      .super_i (req_ctl_q.sup),
      .hit_o   (tab_hit[t]),
      .rights_o(tab_rgt[t])
    );
  end

  logic is_fetch;
  logic pages_differ;
  assign is_fetch     = (req_ctl_q.acc == ACC_FETCH);
  assign pages_differ = tab_xlat[0][ADDR_W-1:PAGE_BITS] != tab_xlat[1][ADDR_W-1:PAGE_BITS];

  // when pages disagree keep only the side the access needs
  always_comb begin
    for (int t = 0; t < NTAB; t++) begin
      sel_match[t] = tab_match[t];
      sel_xlat[t]  = tab_xlat[t];
    end
    if (pages_differ) begin
      if (is_fetch) begin
        sel_match[1] = '0;
        sel_xlat[1]  = '0;
      end else begin
        sel_match[0] = '0;
        sel_xlat[0]  = '0;
      end
    end
  end

  logic unused_xlat;
  assign unused_xlat = ^{sel_xlat[0][PAGE_BITS-1:PERM_LSB+PERM_W], sel_xlat[0][PERM_LSB-1:0],
                         sel_xlat[1][PAGE_BITS-1:PERM_LSB+PERM_W], sel_xlat[1][PERM_LSB-1:0]};

  logic [2:0] need;
  logic [2:0] granted;
  logic [2:0] valid_v;
  logic       side_on;
  exc_e       exc;

  always_comb begin
    need = '0;
    unique case (req_ctl_q.acc)
      ACC_FETCH: need[RGT_X] = 1'b1;
      ACC_STORE: need[RGT_W] = 1'b1;
      default:   need[RGT_R] = 1'b1;
    endcase
  end

  always_comb begin
    granted        = tab_rgt[0] | tab_rgt[1];
    valid_v        = '0;
    valid_v[RGT_X] = tab_hit[0];
    valid_v[RGT_R] = tab_hit[1];
    valid_v[RGT_W] = tab_hit[1];
    side_on        = is_fetch ? req_ctl_q.ien : req_ctl_q.den;
    if (!side_on) begin
      rsp_paddr_o  = req_va_q;
      rsp_rights_o = '1;
      exc          = EXC_NONE;
    end else begin
      rsp_paddr_o  = {sel_xlat[0][ADDR_W-1:PAGE_BITS] | sel_xlat[1][ADDR_W-1:PAGE_BITS],
                      req_va_q[PAGE_BITS-1:0]};
      rsp_rights_o = granted;
      if (|(need & granted))      exc = EXC_NONE;
      else if (|(need & valid_v)) exc = is_fetch ? EXC_IPAGE : EXC_DPAGE;
      else                        exc = is_fetch ? EXC_ITLB_MISS : EXC_DTLB_MISS;
    end
  end

  assign rsp_valid_o   = req_vld_q;
  assign rsp_exc_o     = exc;
  assign resv_cancel_o = req_vld_q && (exc != EXC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            fault_addr_o <= '0;
    else if (resv_cancel_o) fault_addr_o <= req_va_q;
  end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_vaddr_i,
  input logic [1:0]        req_type_i,
  input logic              itrans_en_i,
  input logic              dtrans_en_i,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] rsp_paddr_o,
  input logic [2:0]        rsp_rights_o,
  input logic [2:0]        rsp_exc_o,
  input logic [ADDR_W-1:0] fault_addr_o,
  input logic              resv_cancel_o
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R1
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R1
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_paddr_o[PAGE_BITS-1:0] == $past(req_vaddr_i[PAGE_BITS-1:0])); // R3
  AST_STORE_FAULT_IFF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_type_i == 2'd2 && dtrans_en_i |=> ((rsp_exc_o == 3'd0) == rsp_rights_o[1])); // R5
  AST_FETCH_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_type_i == 2'd0 |=> (rsp_exc_o == 3'd0 || rsp_exc_o == 3'd1 || rsp_exc_o == 3'd3)); // R5
  AST_FETCH_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_type_i == 2'd0 && !itrans_en_i |=>
      (rsp_paddr_o == $past(req_vaddr_i) && rsp_rights_o == 3'b111 && rsp_exc_o == 3'd0)); // R7
  AST_DATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_type_i != 2'd0 && !dtrans_en_i |=>
      (rsp_paddr_o == $past(req_vaddr_i) && rsp_rights_o == 3'b111 && rsp_exc_o == 3'd0)); // R7
  AST_FAULT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_exc_o != 3'd0 |=> fault_addr_o == $past(req_vaddr_i, 2)); // R8
  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && rsp_exc_o != 3'd0) |=> $stable(fault_addr_o)); // R8
  AST_CANCEL_IN_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resv_cancel_o |-> rsp_valid_o); // R8
endmodule

bind tlb_lookup tlb_lookup_chk #(
  .ADDR_W   (ADDR_W),
  .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_vaddr_i  (req_vaddr_i),
  .req_type_i   (req_type_i),
  .itrans_en_i  (itrans_en_i),
  .dtrans_en_i  (dtrans_en_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_paddr_o  (rsp_paddr_o),
  .rsp_rights_o (rsp_rights_o),
  .rsp_exc_o    (rsp_exc_o),
  .fault_addr_o (fault_addr_o),
  .resv_cancel_o(resv_cancel_o)
);

// File: tb/tlb_lookup_bench.sv
`timescale 1ns/1ps
module tlb_lookup_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0]  req_type_i = '0;
  logic        req_super_i = 1'b0;
  logic        itrans_en_i = 1'b1;
  logic        dtrans_en_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic        wr_dtable_i = 1'b0;
  logic [5:0]  wr_idx_i = '0;
  logic        wr_word_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_paddr_o;
  logic [2:0]  rsp_rights_o;
  logic [2:0]  rsp_exc_o;
  logic [31:0] fault_addr_o;
  logic        resv_cancel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_fault = '0;

  always #2.5 clk = ~clk;

  tlb_lookup u_tlb_lookup (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i), .req_type_i(req_type_i),
    .req_super_i(req_super_i), .itrans_en_i(itrans_en_i), .dtrans_en_i(dtrans_en_i),
    .wr_en_i(wr_en_i), .wr_dtable_i(wr_dtable_i), .wr_idx_i(wr_idx_i),
    .wr_word_i(wr_word_i), .wr_data_i(wr_data_i),
    .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o), .rsp_rights_o(rsp_rights_o),
    .rsp_exc_o(rsp_exc_o), .fault_addr_o(fault_addr_o), .resv_cancel_o(resv_cancel_o)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  typ;
    logic        sup;
    logic        ien;
    logic        den;
    logic [31:0] pa;
    logic [2:0]  rgt;
    logic [2:0]  exc;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h0004_2ABC, 2'd0, 1'b1, 1'b1, 1'b1, 32'h1230_0ABC, 3'b111, 3'd0, 8'd4},  // R4 super fetch
    '{32'h0004_2ABC, 2'd0, 1'b0, 1'b1, 1'b1, 32'h1230_0ABC, 3'b001, 3'd3, 8'd5},  // R5 ipf
    '{32'h0004_2ABC, 2'd2, 1'b0, 1'b1, 1'b1, 32'h1230_0ABC, 3'b001, 3'd4, 8'd5},  // R5 dpf store
    '{32'h0004_2ABC, 2'd1, 1'b0, 1'b1, 1'b1, 32'h1230_0ABC, 3'b001, 3'd0, 8'd4},  // R4 user load
    '{32'h0004_2ABC, 2'd2, 1'b1, 1'b1, 1'b1, 32'h1230_0ABC, 3'b111, 3'd0, 8'd4},  // R4 super store
    '{32'h0004_4010, 2'd1, 1'b0, 1'b1, 1'b1, 32'h0ABC_0010, 3'b011, 3'd0, 8'd6},  // R6 instr side dropped
    '{32'h0004_4010, 2'd0, 1'b0, 1'b1, 1'b1, 32'h0000_0010, 3'b000, 3'd1, 8'd6},  // R6 data side dropped
    '{32'h0004_4010, 2'd1, 1'b1, 1'b1, 1'b1, 32'h0ABC_0010, 3'b000, 3'd4, 8'd4},  // R4 super lacks read
    '{32'h0014_4010, 2'd1, 1'b0, 1'b1, 1'b1, 32'h0ABC_0010, 3'b000, 3'd2, 8'd2},  // R2 tag alias miss
    '{32'h0014_2ABC, 2'd0, 1'b0, 1'b1, 1'b1, 32'h1230_0ABC, 3'b000, 3'd1, 8'd2},  // R2 tag alias miss
    '{32'h0004_2ABC, 2'd3, 1'b0, 1'b1, 1'b1, 32'h1230_0ABC, 3'b001, 3'd0, 8'd5},  // R5 type 3 is load
    '{32'h0014_2ABC, 2'd0, 1'b1, 1'b0, 1'b1, 32'h0014_2ABC, 3'b111, 3'd0, 8'd7},  // R7 instr off
    '{32'h0014_4010, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0014_4010, 3'b111, 3'd0, 8'd7},  // R7 data off
    '{32'h0004_2ABC, 2'd0, 1'b1, 1'b1, 1'b0, 32'h1230_0ABC, 3'b111, 3'd0, 8'd7},  // R7 data off, fetch on
    '{32'h0000_0123, 2'd2, 1'b1, 1'b1, 1'b1, 32'hFFFF_E123, 3'b011, 3'd0, 8'd2},  // R2 index 0
    '{32'h0007_FFFF, 2'd0, 1'b0, 1'b1, 1'b1, 32'h8000_1FFF, 3'b100, 3'd0, 8'd2}   // R2 index 63
  };

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // call after a negedge; returns after the negedge of the response cycle
  task automatic do_req(input logic [31:0] va, input logic [1:0] typ, input logic sup,
                        input logic ien, input logic den);
    req_valid_i = 1'b1;
    req_vaddr_i = va;
    req_type_i  = typ;
    req_super_i = sup;
    itrans_en_i = ien;
    dtrans_en_i = den;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    wr_en_i     = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic tab, input logic [5:0] idx, input logic word, input logic [31:0] d);
    wr_en_i     = 1'b1;
    wr_dtable_i = tab;
    wr_idx_i    = idx;
    wr_word_i   = word;
    wr_data_i   = d;
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10", "rsp_valid after reset", 32'(rsp_valid_o), 32'd0);
    chk("R10", "fault_addr after reset", fault_addr_o, 32'd0);
    chk("R10", "resv_cancel after reset", 32'(resv_cancel_o), 32'd0);
    do_req(32'h0004_2ABC, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R10", "empty fetch exc", 32'(rsp_exc_o), 32'd1);
    step();
    do_req(32'h0004_2ABC, 2'd1, 1'b1, 1'b1, 1'b1);
    chk("R10", "empty load exc", 32'(rsp_exc_o), 32'd2);
    exp_fault = 32'h0004_2ABC;
    step();

    wr(1'b0, 6'd33, 1'b0, 32'h0004_2001);
    wr(1'b0, 6'd33, 1'b1, 32'h1230_0040);
    wr(1'b1, 6'd33, 1'b0, 32'h0004_2001);
    wr(1'b1, 6'd33, 1'b1, 32'h1230_0340);
    wr(1'b1, 6'd34, 1'b0, 32'h0004_4001);
    wr(1'b1, 6'd34, 1'b1, 32'h0ABC_00C0);
    wr(1'b1, 6'd0,  1'b0, 32'h0000_0001);
    wr(1'b1, 6'd0,  1'b1, 32'hFFFF_E300);
    wr(1'b0, 6'd63, 1'b0, 32'h0007_E001);
    wr(1'b0, 6'd63, 1'b1, 32'h8000_0080);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      automatic string rq = $sformatf("R%0d", v.req);
      do_req(v.va, v.typ, v.sup, v.ien, v.den);
      chk("R1", "rsp_valid in response cycle", 32'(rsp_valid_o), 32'd1);
      chk(rq, "paddr", rsp_paddr_o, v.pa);
      chk(rq, "rights", 32'(rsp_rights_o), 32'(v.rgt));
      chk(rq, "exc", 32'(rsp_exc_o), 32'(v.exc));
      chk("R8", "resv_cancel", 32'(resv_cancel_o), 32'(v.exc != 3'd0));
      if (v.exc != 3'd0) exp_fault = v.va;
      step();
      chk("R1", "rsp_valid after response", 32'(rsp_valid_o), 32'd0);
      chk("R8", "fault_addr", fault_addr_o, exp_fault);
    end

    // R9 write landing in the same cycle as the request
    wr_en_i = 1'b1; wr_dtable_i = 1'b0; wr_idx_i = 6'd33; wr_word_i = 1'b0; wr_data_i = 32'h0;
    do_req(32'h0004_2ABC, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R9", "same-cycle invalidate fetch exc", 32'(rsp_exc_o), 32'd1);
    step();
    do_req(32'h0004_2ABC, 2'd1, 1'b0, 1'b1, 1'b1);
    chk("R9", "data table untouched exc", 32'(rsp_exc_o), 32'd0);
    chk("R9", "data table untouched rights", 32'(rsp_rights_o), 32'b001);
    step();
    wr(1'b0, 6'd33, 1'b0, 32'h0004_2001);
    do_req(32'h0004_2ABC, 2'd0, 1'b1, 1'b1, 1'b1);
    chk("R9", "rewritten entry fetch exc", 32'(rsp_exc_o), 32'd0);
    chk("R9", "rewritten entry rights", 32'(rsp_rights_o), 32'b111);
    step();

    // R10 reset in mid-run drops every entry
    do_reset();
    chk("R10", "fault_addr cleared", fault_addr_o, 32'd0);
    do_req(32'h0004_2ABC, 2'd1, 1'b1, 1'b1, 1'b1);
    chk("R10", "load after reset exc", 32'(rsp_exc_o), 32'd2);
    chk("R10", "load after reset rights", 32'(rsp_rights_o), 32'd0);
    step();

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule